// File: doc/BRIEF.md
# Type-C Crosspoint Mode Controller

This block is the control plane of a four-channel Type-C redriver crosspoint. It samples logic-level configuration pins (mode select, alternate-mode kind, source/sink orientation, plug flip and a cable-end swap) and turns them into static per-channel controls. Each of the four high-speed channels gets an enable, a direction bit, an equalizer-source select and a role tag. It also drives the two AUX-to-SBU switch selects, which open only after the alternate-mode enable pin has stayed low for a timed interval.

Channels are indexed 0 = first receive pair, 1 = first transmit pair, 2 = second receive pair, 3 = second transmit pair. After reset the block is held in a USB-only default that ignores the mode pins. A low-high-low pulse on the low mode pin releases it. Every pin passes through a two-flop synchronizer, and all outputs are registered.

Top module: `tcx_mode_ctrl`

## Requirements
- R1: A synchronous reset clears all channel outputs and both AUX selects to zero (AUX open), and it re-arms the USB-only default.
- R2: While the default is armed, the channels decode as mode 01 whatever `mode_sel` holds, and `flip`, `orient_sink`, `alt_custom` and `xswap` still apply. The default is released only after `mode_sel[0]` is seen high and then low. Once released, it stays released until the next reset.
- R3: `mode_sel` encodes the mode: 00 turns every channel off, 01 is USB only (two channels), 10 is four alternate-mode lanes, and 11 is USB on one pair plus alternate-mode lanes on the other pair.
- R4: With `flip` low, USB uses channels 0/1. With `flip` high, USB uses channels 2/3. In mode 11 the alternate-mode lanes take the other pair.
- R5: In source orientation with `xswap` low, the attributes of an enabled channel are as follows. A USB receive channel (0 or 2) has dir=1 and eq=1. A USB transmit channel (1 or 3) has dir=0 and eq=0. A DisplayPort lane has dir=0, eq=0 and role 10. A custom lane follows the USB rule for dir and eq and has role 11. The USB role is 01 and the off role is 00.
- R6: With `orient_sink` high, the direction bit of every USB and custom lane is inverted. DisplayPort lanes are not affected.
- R7: With `xswap` high, both the direction bit and the eq bit of every enabled channel are inverted.
- R8: While `alt_en` is high, the AUX selects are `aux_p_sel`=01 and `aux_n_sel`=10 when `flip` is low, and they are crossed (10/01) when `flip` is high. Bit 0 means SBU1 and bit 1 means SBU2. The two selects never share a bit.
- R9: After `alt_en` goes low, the AUX selects keep their last value for OPEN_CYC synchronized cycles (CLK_HZ/500, which is 2 ms). After that they are both 00.
- R10: `alt_en` returning high restarts the timer and restores the FLIP-based mapping on the next cycle after it is synchronized. A low period shorter than the limit never opens the switches.
- R11: A pin change reaches the channel outputs on the third rising edge after it is applied. A disabled channel shows zero in every field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| rst | input | 1 | Synchronous active-high reset |
| orient_sink | input | 1 | 0 = source side, 1 = sink side |
| alt_custom | input | 1 | 0 = DisplayPort lanes, 1 = custom lanes |
| mode_sel | input | 2 | Operating mode (bit 1 also enables AUX) |
| flip | input | 1 | Plug orientation |
| xswap | input | 1 | Reverse all directions and exchange EQ sources |
| ch_en | output | 4 | Per-channel enable |
| ch_dir | output | 4 | Per-channel direction (0 = upstream to downstream) |
| ch_eq | output | 4 | Per-channel EQ source (0 = upstream, 1 = downstream) |
| ch_role | output | 8 | Two bits per channel: 00 off, 01 USB, 10 DP lane, 11 custom lane |
| aux_p_sel | output | 2 | AUXP switch select (bit0 SBU1, bit1 SBU2, 00 open) |
| aux_n_sel | output | 2 | AUXN switch select |

## Verification
A default flag that is stuck or released too early shows up as alternate-mode roles or powered-down channels within six cycles of the mode pins moving. That is visible long before any pulse on `mode_sel[0]`. A wrong pair choice or a wrong direction or eq term shows on the very next decode as a mismatch on one channel's field. An AUX timer that is off by a large margin, or that misses its cancel, is caught by sampling on both sides of the 2 ms boundary and again after a short low pulse.

// File: rtl/tcx_pkg.sv
package tcx_pkg;
  localparam int NUM_CH = 4;
  localparam int ROLE_W = 2;

  typedef enum logic [ROLE_W-1:0] {
    ROLE_OFF  = 2'b00,
    ROLE_USB  = 2'b01,
    ROLE_DP   = 2'b10,
    ROLE_CUST = 2'b11
  } role_e;

  typedef struct packed {
    logic  en;
    logic  dir;
    logic  eq;
    role_e role;
  } chan_cfg_t;

  localparam logic [1:0] MODE_OFF  = 2'b00;
  localparam logic [1:0] MODE_USB  = 2'b01;
  localparam logic [1:0] MODE_ALT4 = 2'b10;
  localparam logic [1:0] MODE_MIX  = 2'b11;
endpackage

// File: rtl/tcx_sync.sv
module tcx_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
    end else begin
      stage_q[0] <= d;
      for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/tcx_lane_cfg.sv
module tcx_lane_cfg
  import tcx_pkg::*;
#(
  parameter int CH_IDX = 0
) (
  input  logic [1:0] mode,
  input  logic       flip,
  input  logic       sink,
  input  logic       custom,
  input  logic       swap,
  output chan_cfg_t  cfg
);
  localparam bit IS_RX    = (CH_IDX % 2) == 0;
  localparam bit ON_PAIR2 = CH_IDX >= 2;

  logic  usb_pair;
  logic  active;
  role_e role;
  logic  dir_base;

  assign usb_pair = (ON_PAIR2 == flip);

  always_comb begin
    active = 1'b0;
    role   = ROLE_OFF;
    unique case (mode)
      MODE_USB:  begin active = usb_pair; role = ROLE_USB; end
      MODE_ALT4: begin active = 1'b1;     role = custom ? ROLE_CUST : ROLE_DP; end
      MODE_MIX:  begin
        active = 1'b1;
        role   = usb_pair ? ROLE_USB : (custom ? ROLE_CUST : ROLE_DP);
      end
      default:   begin active = 1'b0;     role = ROLE_OFF; end
    endcase
  end

  always_comb begin
    cfg = '0;
    if (active) begin
      if (role == ROLE_DP) begin
        dir_base = 1'b0;
        cfg.eq   = 1'b0;
      end else begin
        dir_base = IS_RX ^ sink;
        cfg.eq   = IS_RX;
      end
      cfg.en   = 1'b1;
      cfg.dir  = dir_base ^ swap;
      cfg.eq   = cfg.eq ^ swap;
      cfg.role = role;
    end else begin
      dir_base = 1'b0;
    end
  end
endmodule

// File: rtl/tcx_aux_timer.sv
module tcx_aux_timer #(
  parameter int unsigned OPEN_CYC = 250000,
  localparam int CNT_W = $clog2(OPEN_CYC + 1)
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       alt_on,
  input  logic       flip,
  output logic [1:0] p_sel,
  output logic [1:0] n_sel
);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(OPEN_CYC);

  logic [CNT_W-1:0] cnt_q;
  logic [1:0]       p_q, n_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= LIMIT;
      p_q   <= 2'b00;
      n_q   <= 2'b00;
    end else if (alt_on) begin
      cnt_q <= '0;
      p_q   <= flip ? 2'b10 : 2'b01;
      n_q   <= flip ? 2'b01 : 2'b10;
    end else if (cnt_q == LIMIT) begin
      p_q   <= 2'b00;
      n_q   <= 2'b00;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign p_sel = p_q;
  assign n_sel = n_q;

  AST_AUX_DISJOINT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(p_q) && $onehot0(n_q) && ((p_q & n_q) == 2'b00)); // R8
  AST_AUX_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!alt_on && cnt_q != LIMIT) |=> $stable(p_q) && $stable(n_q)); // R9
  AST_AUX_CANCEL: assert property (@(posedge clk) disable iff (rst)
    alt_on |=> (p_q != 2'b00) && (cnt_q == '0)); // R10
endmodule

// File: rtl/tcx_mode_ctrl.sv
module tcx_mode_ctrl
  import tcx_pkg::*;
#(
  parameter int unsigned CLK_HZ = 125000000,
  localparam int unsigned OPEN_CYC = CLK_HZ / 500
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      orient_sink,
  input  logic                      alt_custom,
  input  logic [1:0]                mode_sel,
  input  logic                      flip,
  input  logic                      xswap,
  output logic [NUM_CH-1:0]         ch_en,
  output logic [NUM_CH-1:0]         ch_dir,
  output logic [NUM_CH-1:0]         ch_eq,
  output logic [NUM_CH*ROLE_W-1:0]  ch_role,
  output logic [1:0]                aux_p_sel,
  output logic [1:0]                aux_n_sel
);
  localparam int PIN_W = 6;

  logic [PIN_W-1:0] pins_s;
  logic             sink_s, cust_s, flip_s, swap_s;
  logic [1:0]       mode_s;

  tcx_sync #(.WIDTH(PIN_W), .STAGES(2)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({xswap, flip, mode_sel, alt_custom, orient_sink}),
    .q   (pins_s)
  );
  assign {swap_s, flip_s, mode_s, cust_s, sink_s} = pins_s;

  // power-up USB-only hold, released by low-high-low on mode bit 0
  logic pdef_q, seen_hi_q;
  always_ff @(posedge clk) begin
    if (rst) begin
      pdef_q    <= 1'b1;
      seen_hi_q <= 1'b0;
    end else if (pdef_q) begin
      if (mode_s[0])      seen_hi_q <= 1'b1;
      else if (seen_hi_q) pdef_q    <= 1'b0;
    end
  end

  logic [1:0] mode_eff;
  assign mode_eff = pdef_q ? MODE_USB : mode_s;

  chan_cfg_t cfg_d [NUM_CH];
  chan_cfg_t cfg_q [NUM_CH];

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    tcx_lane_cfg #(.CH_IDX(c)) u_lane (
      .mode   (mode_eff),
      .flip   (flip_s),
      .sink   (sink_s),
      .custom (cust_s),
      .swap   (swap_s),
      .cfg    (cfg_d[c])
    );

    always_ff @(posedge clk) begin
      if (rst) cfg_q[c] <= '0;
      else     cfg_q[c] <= cfg_d[c];
    end

    assign ch_en[c]                   = cfg_q[c].en;
    assign ch_dir[c]                  = cfg_q[c].dir;
    assign ch_eq[c]                   = cfg_q[c].eq;
    assign ch_role[c*ROLE_W +: ROLE_W] = cfg_q[c].role;

    AST_OFF_ZERO: assert property (@(posedge clk) disable iff (rst)
      !cfg_q[c].en |-> (!cfg_q[c].dir && !cfg_q[c].eq && cfg_q[c].role == ROLE_OFF)); // R11
    AST_DEFAULT_NO_ALT: assert property (@(posedge clk) disable iff (rst)
      pdef_q |=> (cfg_q[c].role != ROLE_DP && cfg_q[c].role != ROLE_CUST)); // R2
  end

  tcx_aux_timer #(.OPEN_CYC(OPEN_CYC)) u_aux (
    .clk    (clk),
    .rst    (rst),
    .alt_on (mode_s[1]),
    .flip   (flip_s),
    .p_sel  (aux_p_sel),
    .n_sel  (aux_n_sel)
  );

  AST_DEFAULT_ONEWAY: assert property (@(posedge clk) disable iff (rst)
    !pdef_q |=> !pdef_q); // R2
  AST_DEFAULT_USB_PAIR: assert property (@(posedge clk) disable iff (rst)
    pdef_q |=> ($countones(ch_en) == 2)); // R2
endmodule

// File: tb/sim_tcx_mode_ctrl.sv
module sim_tcx_mode_ctrl;
  localparam int CLK_HZ = 50000;
  localparam int OPEN   = CLK_HZ / 500;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic orient_sink = 0, alt_custom = 0, flip = 0, xswap = 0;
  logic [1:0] mode_sel = 2'b00;
  logic [3:0] ch_en, ch_dir, ch_eq;
  logic [7:0] ch_role;
  logic [1:0] aux_p_sel, aux_n_sel;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #4 clk = ~clk;

  tcx_mode_ctrl #(.CLK_HZ(CLK_HZ)) u0 (
    .clk(clk), .rst(rst), .orient_sink(orient_sink), .alt_custom(alt_custom),
    .mode_sel(mode_sel), .flip(flip), .xswap(xswap),
    .ch_en(ch_en), .ch_dir(ch_dir), .ch_eq(ch_eq), .ch_role(ch_role),
    .aux_p_sel(aux_p_sel), .aux_n_sel(aux_n_sel)
  );

  // expected {en,dir,eq,role[1:0]} for one channel, from the requirements
  function automatic logic [4:0] model(int ch, logic [1:0] m, logic fl, logic sk,
                                       logic cu, logic sw);
    logic on_usb, rx, en, d, e;
    logic [1:0] r;
    on_usb = fl ? (ch >= 2) : (ch < 2);
    rx = (ch == 0) || (ch == 2);
    case (m)
      2'b01:   begin en = on_usb; r = on_usb ? 2'b01 : 2'b00; end
      2'b10:   begin en = 1'b1;   r = cu ? 2'b11 : 2'b10; end
      2'b11:   begin en = 1'b1;   r = on_usb ? 2'b01 : (cu ? 2'b11 : 2'b10); end
      default: begin en = 1'b0;   r = 2'b00; end
    endcase
    if (!en) return 5'b0;
    if (r == 2'b10) begin d = 1'b0; e = 1'b0; end
    else begin d = rx ^ sk; e = rx; end
    return {1'b1, d ^ sw, e ^ sw, r};
  endfunction

  task automatic check_ch(string tag, logic [1:0] m);
    for (int c = 0; c < 4; c++) begin
      logic [4:0] exp_v, act;
      exp_v = model(c, m, flip, orient_sink, alt_custom, xswap);
      act = {ch_en[c], ch_dir[c], ch_eq[c], ch_role[2*c +: 2]};
      total++;
      if (act !== exp_v) begin
        bad++;
        $display("FAIL %s ch%0d act=%b exp=%b", tag, c, act, exp_v);
      end
    end
  endtask

  task automatic check_aux(string tag, logic [1:0] ep, logic [1:0] en_);
    total++;
    if (aux_p_sel !== ep || aux_n_sel !== en_) begin
      bad++;
      $display("FAIL %s aux act=%b/%b exp=%b/%b", tag, aux_p_sel, aux_n_sel, ep, en_);
    end
  endtask

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_pins(logic d0, logic d1, logic [1:0] m, logic fl, logic sw);
    orient_sink = d0; alt_custom = d1; mode_sel = m; flip = fl; xswap = sw;
  endtask

  task automatic release_default();
    mode_sel = 2'b01; wait_n(6);
    mode_sel = 2'b00; wait_n(6);
  endtask

  initial begin
    void'($urandom(32'd11));
    set_pins(0, 0, 2'b10, 0, 0);
    wait_n(3);
    // R1: reset state
    check_ch("R1", 2'b00);
    check_aux("R1", 2'b00, 2'b00);
    rst = 0;
    wait_n(6);
    // R2: default overrides mode pins
    check_ch("R2", 2'b01);
    mode_sel = 2'b00; wait_n(6);
    check_ch("R2", 2'b01);
    set_pins(1, 1, 2'b10, 1, 1); wait_n(6);
    check_ch("R2", 2'b01);
    mode_sel = 2'b11; wait_n(6);            // high seen, still default
    check_ch("R2", 2'b01);
    mode_sel = 2'b10; wait_n(6);            // low again: released
    check_ch("R2", 2'b10);
    mode_sel = 2'b00; wait_n(6);
    check_ch("R3", 2'b00);

    // full directed sweep
    for (int k = 0; k < 64; k++) begin
      string tag;
      set_pins(k[0], k[1], k[3:2], k[4], k[5]);
      wait_n(4);
      if (k[5]) tag = "R7";
      else if (k[0]) tag = "R6";
      else if (k[4]) tag = "R4";
      else if (k[3]) tag = "R5";
      else tag = "R3";
      check_ch(tag, k[3:2]);
    end

    // R11: latency exactly three rising edges
    set_pins(0, 0, 2'b01, 0, 0); wait_n(5);
    mode_sel = 2'b11;
    wait_n(2);
    check_ch("R11", 2'b01);
    wait_n(1);
    check_ch("R11", 2'b11);

    // R8: AUX mapping both orientations
    flip = 0; wait_n(4);
    check_aux("R8", 2'b01, 2'b10);
    flip = 1; wait_n(4);
    check_aux("R8", 2'b10, 2'b01);

    // R9: hold then open
    mode_sel = 2'b01;
    wait_n(OPEN - 10);
    check_aux("R9", 2'b10, 2'b01);
    wait_n(20);
    check_aux("R9", 2'b00, 2'b00);
    // R10: return high restores mapping
    flip = 0; mode_sel = 2'b10; wait_n(4);
    check_aux("R10", 2'b01, 2'b10);
    // R10: short lows never open
    mode_sel = 2'b00; wait_n(OPEN * 2 / 3);
    mode_sel = 2'b10; wait_n(4);
    mode_sel = 2'b00; wait_n(OPEN * 2 / 3);
    check_aux("R10", 2'b01, 2'b10);
    mode_sel = 2'b10; wait_n(4);

    // random phase
    for (int i = 0; i < 300; i++) begin
      logic [5:0] r;
      r = 6'($urandom());
      set_pins(r[0], r[1], r[3:2], r[4], r[5]);
      wait_n(4);
      check_ch("R5", r[3:2]);
      if (r[3]) check_aux("R8", r[4] ? 2'b10 : 2'b01, r[4] ? 2'b01 : 2'b10);
    end

    // R1/R2: reset re-arms default
    set_pins(0, 0, 2'b10, 0, 0);
    @(negedge clk); rst = 1; wait_n(2); rst = 0;
    wait_n(6);
    check_ch("R1", 2'b01);
    release_default();
    mode_sel = 2'b11; wait_n(4);
    check_ch("R2", 2'b11);

    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog act=hung exp=done");
      end
    join_any
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule